// File: doc/BRIEF.md
# Six-Channel DAC Code Register Bank with Paired Update

This block is a byte-wide I/O bus slave. It stores 12-bit codes for six DAC channels and decides when each channel's output latch takes a new code. It answers to a window of 16 byte addresses. The window base is aligned to 16 bytes and is selected by six switch inputs. Offsets 0 to 11 hold the DAC registers. Each channel has two of them: the even offset holds the low byte and the odd offset holds the upper four bits. Offsets 12 to 15 are not decoded here. The block only raises a select for them, so that a separate parallel-port block can respond.

Software loads a channel by writing the low byte first and the upper nibble second. The low byte goes into a holding register only. Channels are grouped in fixed pairs, and each pair has its own mode input:

- **Transfer mode:** the nibble write moves the full code to the output latch at once.
- **Simultaneous mode:** the nibble write only stages the code. Every staged code moves to its latch together when any bus read hits offsets 0 to 12.

A global power-up mode input can hold all outputs at zero, with their enables low. The hold lasts until software writes an upper nibble and then reads a DAC offset.

Top module: `dac_bank_ctrl`

## Requirements
- R1: After a synchronous active-low reset, every holding register and output latch is zero. The output enables are all 1 in standard mode and all 0 in zero-hold mode.
- R2: An access hits the block only when `bus_addr[9:4]` equals `base_sw`. Offset `bus_addr[3:0]` = 2n addresses channel n's low byte, and offset 2n+1 addresses its upper nibble, for n = 0..5. An access with any other base changes nothing.
- R3: A low-byte write loads only the holding register. It leaves every channel's output code unchanged.
- R4: In transfer mode (pair mode bit = 0), an upper-nibble write sets the channel's output code to {wdata[3:0], held low byte} at the clock edge that samples the write.
- R5: `pair_sim[k]` sets the mode of channels 2k and 2k+1 together, for k = 0..2.
- R6: In simultaneous mode (pair mode bit = 1), an upper-nibble write leaves the output unchanged. A read strobe at offsets 0 to 12 moves {held nibble, held low byte} to the latch of every simultaneous-mode channel. A read at offsets 13 to 15 moves nothing.
- R7: With `zero_pwr` = 1, all codes read as zero and all enables are 0. This holds until an upper-nibble write to any channel is followed by a read at offsets 0 to 11. A read before any nibble write does not release the hold.
- R8: With `zero_pwr` = 0, every enable is 1 and each code output shows its latch directly.
- R9: Bits 7:4 of an upper-nibble write have no effect on any output code.
- R10: `port_sel` is 1, without a clock, exactly when the base matches and the offset is 12 to 15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 10 | I/O bus address |
| bus_wdata | input | 8 | Write data byte |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| base_sw | input | 6 | Window base, compared with address bits 9:4 |
| pair_sim | input | 3 | Per-pair mode: 1 = simultaneous, 0 = transfer |
| zero_pwr | input | 1 | 1 = hold outputs at zero until released |
| dac_code | output | 72 | Latched codes; channel n occupies bits 12n+11:12n |
| dac_oe | output | 6 | Per-channel output enable |
| port_sel | output | 1 | Access targets offsets 12..15 |

## Verification
The main function is tried with four kinds of stimulus:

- A low-then-high write pair on a transfer pair. This separates a staged load from an immediate transfer.
- The same pair of writes on a simultaneous pair, followed by reads at offset 12 and offset 13. This separates the read offsets that trigger an update from those that do not.
- A write through a non-matching base. This shows whether the decode compares the right address bits.
- The zero-hold mode driven with a read before and after the first nibble write. This shows that the release needs both steps in that order.

// File: rtl/dacb_pkg.sv
// Shared sizing for the DAC register bank.
// Assumes a 16-byte window with two registers per channel at the bottom.
package dacb_pkg;
    localparam int ADDR_W    = 10;
    localparam int OFF_W     = 4;
    localparam int BASE_W    = ADDR_W - OFF_W;
    localparam int BYTE_W    = 8;
    localparam int CODE_W    = 12;
    localparam int HI_W      = CODE_W - BYTE_W;
    localparam int PORT_REGS = 4;
endpackage

// File: rtl/dacb_decode.sv
// Address decode for the register window.
// Turns bus strobes into per-register write pulses, DAC-read and
// update-read pulses, and the port select. Assumes one-cycle strobes.
module dacb_decode
    import dacb_pkg::*;
#(
    parameter int NUM_CH = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BASE_W-1:0] base_sw,
    input  logic              wr,
    input  logic              rd,
    output logic [NUM_CH-1:0] wr_lo,
    output logic [NUM_CH-1:0] wr_hi,
    output logic              rd_dac,
    output logic              rd_xfer,
    output logic              port_sel
);
    localparam int DAC_REGS  = 2 * NUM_CH;
    localparam int PORT_BASE = (1 << OFF_W) - PORT_REGS;

    logic              match;
    logic [OFF_W-1:0]  off;

    // Window match on the upper address bits
    always_comb begin
        match = (addr[ADDR_W-1:OFF_W] == base_sw);
        off   = addr[OFF_W-1:0];
    end

    genvar c;
    generate
        for (c = 0; c < NUM_CH; c++) begin : g_ch
            // Per-channel write pulses: even offset low byte, odd offset nibble
            always_comb begin
                wr_lo[c] = wr && match && (off == OFF_W'(2 * c));
                wr_hi[c] = wr && match && (off == OFF_W'(2 * c + 1));
            end
        end
    endgenerate

    // Read events and the port-block select
    always_comb begin
        rd_dac   = rd && match && (off <  OFF_W'(DAC_REGS));
        rd_xfer  = rd && match && (off <= OFF_W'(DAC_REGS));
        port_sel = match && (off >= OFF_W'(PORT_BASE));
    end

    AST_WR_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wr_lo, wr_hi})); // R2
    AST_PORT_NOT_DAC: assert property (@(posedge clk) disable iff (!rst_n)
        port_sel |-> !rd_dac && (wr_lo == '0) && (wr_hi == '0)); // R10
endmodule

// File: rtl/dacb_channel.sv
// One DAC channel.
// Holds the low byte and upper nibble, and loads the output latch on a
// nibble write (transfer mode) or on an update read (simultaneous mode).
module dacb_channel
    import dacb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic              sim_mode,
    input  logic              xfer_rd,
    input  logic [BYTE_W-1:0] wdata,
    output logic [CODE_W-1:0] code
);
    logic [BYTE_W-1:0] lo_hold;
    logic [HI_W-1:0]   hi_hold;
    logic [CODE_W-1:0] latch_q;

    // Holding registers and output latch update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_hold <= '0;
            hi_hold <= '0;
            latch_q <= '0;
        end else begin
            if (wr_lo)
                lo_hold <= wdata;
            if (wr_hi) begin
                hi_hold <= wdata[HI_W-1:0];
                if (!sim_mode)
                    latch_q <= {wdata[HI_W-1:0], lo_hold};
            end else if (xfer_rd && sim_mode) begin
                latch_q <= {hi_hold, lo_hold};
            end
        end
    end

    assign code = latch_q;

    AST_LO_NO_XFER: assert property (@(posedge clk) disable iff (!rst_n)
        wr_lo |=> $stable(latch_q)); // R3
    AST_XFER_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hi && !sim_mode) |=> (latch_q[BYTE_W-1:0] == $past(lo_hold))); // R4
    AST_SIM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hi && sim_mode) |=> $stable(latch_q)); // R6
endmodule

// File: rtl/dacb_enable.sv
// Power-up interlock.
// In zero-hold mode the outputs stay disabled until a nibble write
// (arm) and then a DAC-offset read (release). In standard mode the
// outputs are always enabled.
module dacb_enable (
    input  logic clk,
    input  logic rst_n,
    input  logic zero_mode,
    input  logic any_hi_wr,
    input  logic dac_rd,
    output logic out_en
);
    logic armed;
    logic released;

    // Two-step release sequence
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed    <= 1'b0;
            released <= 1'b0;
        end else begin
            if (any_hi_wr)
                armed <= 1'b1;
            if (armed && dac_rd)
                released <= 1'b1;
        end
    end

    // Enable is forced high in standard mode
    always_comb out_en = !zero_mode || released;

    AST_RELEASE_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(released) |-> $past(armed) && $past(dac_rd)); // R7
endmodule

// File: rtl/dac_bank_ctrl.sv
// Six-channel DAC code register bank with paired update.
// Top level: decode, one channel slice per output, and the power-up
// interlock. Each mode bit in pair_sim covers two adjacent channels.
module dac_bank_ctrl
    import dacb_pkg::*;
#(
    parameter int NUM_CH = 6,
    localparam int NUM_PAIRS = NUM_CH / 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [ADDR_W-1:0]        bus_addr,
    input  logic [BYTE_W-1:0]        bus_wdata,
    input  logic                     bus_wr,
    input  logic                     bus_rd,
    input  logic [BASE_W-1:0]        base_sw,
    input  logic [NUM_PAIRS-1:0]     pair_sim,
    input  logic                     zero_pwr,
    output logic [NUM_CH*CODE_W-1:0] dac_code,
    output logic [NUM_CH-1:0]        dac_oe,
    output logic                     port_sel
);
    logic [NUM_CH-1:0] wr_lo;
    logic [NUM_CH-1:0] wr_hi;
    logic              rd_dac;
    logic              rd_xfer;
    logic              out_en;

    dacb_decode #(.NUM_CH(NUM_CH)) u_dec (
        .clk      (clk),
        .rst_n    (rst_n),
        .addr     (bus_addr),
        .base_sw  (base_sw),
        .wr       (bus_wr),
        .rd       (bus_rd),
        .wr_lo    (wr_lo),
        .wr_hi    (wr_hi),
        .rd_dac   (rd_dac),
        .rd_xfer  (rd_xfer),
        .port_sel (port_sel)
    );

    dacb_enable u_en (
        .clk       (clk),
        .rst_n     (rst_n),
        .zero_mode (zero_pwr),
        .any_hi_wr (|wr_hi),
        .dac_rd    (rd_dac),
        .out_en    (out_en)
    );

    genvar n;
    generate
        for (n = 0; n < NUM_CH; n++) begin : g_ch
            logic [CODE_W-1:0] code_n;

            dacb_channel u_ch (
                .clk      (clk),
                .rst_n    (rst_n),
                .wr_lo    (wr_lo[n]),
                .wr_hi    (wr_hi[n]),
                .sim_mode (pair_sim[n/2]),
                .xfer_rd  (rd_xfer),
                .wdata    (bus_wdata),
                .code     (code_n)
            );

            // Mask the code while the interlock holds the outputs
            always_comb begin
                dac_code[n*CODE_W +: CODE_W] = out_en ? code_n : '0;
                dac_oe[n]                    = out_en;
            end
        end
    endgenerate

    AST_MASKED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !dac_oe[0] |-> (dac_code == '0)); // R7
    AST_STD_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
        !zero_pwr |-> (dac_oe == '1)); // R8
endmodule

// File: tb/sim_dac_bank_ctrl.sv
// Scoreboard bench for dac_bank_ctrl.
// Bus tasks update a requirement-level model and queue the expected
// outputs. A monitor pops the queue on falling edges and compares.
module sim_dac_bank_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [9:0]  bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [5:0]  base_sw = 6'h30;
    logic [2:0]  pair_sim = 3'b000;
    logic        zero_pwr = 1'b0;
    logic [71:0] dac_code;
    logic [5:0]  dac_oe;
    logic        port_sel;

    int checks = 0;
    int errors = 0;

    typedef struct {
        string       req;
        logic [71:0] code;
        logic [5:0]  oe;
    } exp_t;
    exp_t sbq[$];

    // Requirement-level model state
    logic [7:0]  m_lo[6];
    logic [3:0]  m_hi[6];
    logic [11:0] m_lat[6];
    bit          m_armed;
    bit          m_rel;

    always #4 clk = ~clk;

    dac_bank_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .base_sw(base_sw), .pair_sim(pair_sim),
        .zero_pwr(zero_pwr), .dac_code(dac_code), .dac_oe(dac_oe), .port_sel(port_sel)
    );

    function automatic bit model_en();
        return !zero_pwr || m_rel;
    endfunction

    // Build the expected scoreboard item from the model
    task automatic push(input string req);
        exp_t e;
        e.req = req;
        for (int i = 0; i < 6; i++)
            e.code[i*12 +: 12] = model_en() ? m_lat[i] : 12'h000;
        e.oe = model_en() ? 6'h3F : 6'h00;
        sbq.push_back(e);
    endtask

    // One bus access: strobe for one cycle, then deassert
    task automatic bus_op(input bit is_wr, input logic [9:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = is_wr;
        bus_rd    = !is_wr;
        @(negedge clk);
        bus_wr = 1'b0;
        bus_rd = 1'b0;
    endtask

    task automatic do_reset(input string req);
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < 6; i++) begin
            m_lo[i] = '0; m_hi[i] = '0; m_lat[i] = '0;
        end
        m_armed = 0;
        m_rel   = 0;
        push(req);
    endtask

    task automatic do_wr(input logic [9:0] a, input logic [7:0] d, input string req);
        int ch;
        bus_op(1'b1, a, d);
        if (a[9:4] == base_sw && a[3:0] < 12) begin
            ch = int'(a[3:0]) / 2;
            if (a[0] == 1'b0) begin
                m_lo[ch] = d;
            end else begin
                m_hi[ch] = d[3:0];
                m_armed  = 1;
                if (!pair_sim[ch/2]) m_lat[ch] = {d[3:0], m_lo[ch]};
            end
        end
        push(req);
    endtask

    task automatic do_rd(input logic [9:0] a, input string req);
        bus_op(1'b0, a, 8'h00);
        if (a[9:4] == base_sw && a[3:0] <= 12) begin
            for (int i = 0; i < 6; i++)
                if (pair_sim[i/2]) m_lat[i] = {m_hi[i], m_lo[i]};
            if (a[3:0] < 12 && m_armed) m_rel = 1;
        end
        push(req);
    endtask

    task automatic chk_sel(input logic [9:0] a, input logic expv, input string req);
        @(negedge clk);
        bus_addr = a;
        #1;
        checks++;
        if (port_sel !== expv) begin
            errors++;
            $display("FAIL %s port_sel addr=%h actual=%b expected=%b", req, a, port_sel, expv);
        end
    endtask

    // Monitor: compare outputs with queued expectations
    initial begin
        forever begin
            @(negedge clk);
            while (sbq.size() > 0) begin
                exp_t e;
                e = sbq.pop_front();
                checks++;
                if (dac_code !== e.code || dac_oe !== e.oe) begin
                    errors++;
                    $display("FAIL %s actual code=%h oe=%b expected code=%h oe=%b",
                             e.req, dac_code, dac_oe, e.code, e.oe);
                end
            end
        end
    end

    // Watchdog
    initial begin
        #(8 * 50000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        // Standard mode, all pairs in transfer mode
        do_reset("R1 reset std");
        do_wr(10'h300, 8'h34, "R3 low write holds");
        do_wr(10'h301, 8'hF2, "R4 R9 nibble transfer");
        do_wr(10'h30A, 8'hCD, "R3 ch5 low");
        do_wr(10'h30B, 8'h0A, "R4 ch5 transfer");
        do_wr(10'h310, 8'h77, "R2 base miss low");
        do_wr(10'h311, 8'h07, "R2 base miss nibble");
        do_wr(10'h3F1, 8'h05, "R2 far base miss");
        do_rd(10'h300, "R8 read no change in transfer mode");

        // Pair 1 simultaneous
        pair_sim = 3'b010;
        do_wr(10'h304, 8'h11, "R5 ch2 low");
        do_wr(10'h305, 8'h03, "R6 ch2 nibble staged");
        do_wr(10'h306, 8'h22, "R5 ch3 low");
        do_wr(10'h307, 8'hF9, "R6 R9 ch3 nibble staged");
        do_wr(10'h302, 8'h5A, "R5 ch1 low");
        do_wr(10'h303, 8'h06, "R5 ch1 transfer while pair1 sim");
        do_rd(10'h30D, "R6 read offset 13 no update");
        do_rd(10'h30C, "R6 read offset 12 updates");
        do_wr(10'h305, 8'h0E, "R6 ch2 restage");
        do_rd(10'h30F, "R6 read offset 15 no update");
        do_rd(10'h309, "R6 read offset 9 updates");

        // Base switch change
        base_sw = 6'h00;
        pair_sim = 3'b000;
        do_wr(10'h008, 8'h99, "R2 new base low");
        do_wr(10'h009, 8'h01, "R2 new base nibble");

        // Port select
        base_sw = 6'h30;
        chk_sel(10'h30C, 1'b1, "R10 offset 12");
        chk_sel(10'h30F, 1'b1, "R10 offset 15");
        chk_sel(10'h30B, 1'b0, "R10 offset 11");
        chk_sel(10'h31C, 1'b0, "R10 other base");

        // Zero-hold power-up mode
        zero_pwr = 1'b1;
        do_reset("R1 reset zero mode");
        do_rd(10'h300, "R7 read before nibble write keeps hold");
        do_wr(10'h300, 8'h80, "R7 low write held");
        do_wr(10'h301, 8'h08, "R7 nibble write masked");
        do_rd(10'h30D, "R7 read offset 13 no release");
        do_rd(10'h30C, "R7 read offset 12 no release");
        do_rd(10'h305, "R7 DAC read releases");
        do_wr(10'h303, 8'h04, "R8 after release follows latch");

        repeat (4) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule